// File: doc/BRIEF.md
# Commutation Delay Manager

This block times a brushless motor's electrical steps from the back-EMF zero-crossing events. An 8-bit interval timer, clocked through a power-of-two prescaler, measures the time between accepted zero-crossings. Each accepted crossing moves the measured interval into the current-interval capture and the old value into the previous-interval capture. It also restarts the timer and loads a commutation compare value. That value is the upper byte of the product of a fractional weight and the new interval. When the timer reaches the compare value the block emits a one-cycle commutation pulse.

After a commutation the winding must demagnetise before the next zero-crossing can be trusted. The block waits for a demagnetisation-detected input. If that event never comes, it ends the wait itself when the timer reaches a second, software-set compare value. The prescaler adjusts its range without software help. It coarsens when the timer overflows and refines when a captured interval is short. Both stored intervals are rescaled with it, so they always share one time unit.

Top module: `commutation_delay`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, every output is zero, including `ratio_o`.
- R2: With prescaler code r on `ratio_o`, the timer advances once every 2^r clocks. An accepted zero-crossing sampled at clock edge E, with the previous one at edge P and no overflow in between, captures floor((E-P-1)/2^r) into `zcur_o`. The old `zcur_o` moves to `zprev_o`, and the timer and prescaler restart from zero.
- R3: On each accepted zero-crossing, `comm_cmp_o` becomes bits [15:8] of `weight_i` times the newly captured `zcur_o`. The weight is therefore a fraction of the interval in steps of 1/256.
- R4: For a crossing accepted at edge E with compare value c and code r, `comm_o` is high for exactly one cycle, following edge E + c*2^r + 1.
- R5: A zero-crossing (`zc_i` high) is ignored while the block waits for the commutation or for demagnetisation. It changes no capture and raises no `irq_z_o`.
- R6: A `dem_det_i` pulse during the demagnetisation wait ends the wait. `irq_misc_o` pulses on the following cycle, and the next zero-crossing is accepted.
- R7: During the demagnetisation wait without `dem_det_i`, once the timer is at or above `dsim_cmp_i`, `dsim_o` and `irq_misc_o` pulse for one cycle and the wait ends. A value at or below the commutation compare value fires one cycle after the commutation.
- R8: When the timer would step past 255 while r is below 15, r increases by one, the timer continues from 128, and both `zcur_o` and `zprev_o` are halved (floor). `irq_misc_o` pulses.
- R9: When an accepted capture would be below 64 and r is above 0, r decreases by one. `zcur_o` becomes twice the timer value, and `zprev_o` becomes twice the old `zcur_o`, saturating at 255.
- R10: `irq_z_o` is high for the one cycle that follows each accepted zero-crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zc_i | input | 1 | Back-EMF zero-crossing event, one cycle |
| dem_det_i | input | 1 | Demagnetisation end detected, one cycle |
| weight_i | input | 8 | Commutation delay weight, fraction of 256 |
| dsim_cmp_i | input | 8 | Timer value that ends the demagnetisation wait when no detection arrives |
| comm_o | output | 1 | Commutation event pulse |
| dsim_o | output | 1 | Simulated end-of-demagnetisation pulse |
| irq_z_o | output | 1 | Zero-crossing interrupt source |
| irq_misc_o | output | 1 | Demagnetisation-or-overflow interrupt source |
| zcur_o | output | 8 | Latest interval capture |
| zprev_o | output | 8 | Previous interval capture |
| ratio_o | output | 4 | Prescaler code r, division 2^r |
| comm_cmp_o | output | 8 | Commutation compare value |

## Verification
The assertions take for granted that event inputs are single-cycle pulses and that the weight is stable at the edge that accepts a crossing. The check that ignored crossings leave the capture unchanged excludes overflow cycles, because an overflow rescales the capture on purpose. The stimulus spaces every accepted crossing after the previous commutation and demagnetisation end. It deliberately injects crossings during both wait phases. It lets exactly one interval run past overflow at code 0 and follows it with a short interval that forces the code back down, so every rescaling path is exercised with expected values that can be computed.

// File: rtl/cdm_pkg.sv
// Shared types for the commutation delay manager.
package cdm_pkg;
    // Step phase: waiting for a zero-crossing, for the commutation, or for demagnetisation end.
    typedef enum logic [1:0] {
        PH_WAIT_Z = 2'd0,
        PH_WAIT_C = 2'd1,
        PH_WAIT_D = 2'd2
    } phase_e;
endpackage

// File: rtl/cdm_tick_timer.sv
// Interval timer with a power-of-two prescaler.
// Counts one step every 2^ratio clocks. On stepping past the maximum it resumes
// from mid-scale (the owner doubles the ratio) unless the ratio is already maximal,
// in which case it holds. Assumes ratio changes only on restart or overflow edges.
module cdm_tick_timer #(
    parameter int TMR_W   = 8,
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               restart_i,
    output logic [TMR_W-1:0]   timer_o,
    output logic               ovf_o
);
    localparam int PRE_W = (1 << RATIO_W) - 1;
    localparam logic [TMR_W-1:0]   T_MAX = '1;
    localparam logic [TMR_W-1:0]   T_MID = {1'b1, {(TMR_W-1){1'b0}}};
    localparam logic [RATIO_W-1:0] R_MAX = '1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_mask;
    logic [TMR_W-1:0] timer_q;
    logic             tick;

    assign pre_mask = (PRE_W'(1) << ratio_i) - PRE_W'(1);
    assign tick     = (pre_cnt == pre_mask);
    assign ovf_o    = tick && (timer_q == T_MAX) && !restart_i;
    assign timer_o  = timer_q;

    // Prescaler and timer advance, restart and overflow rescale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            timer_q <= '0;
        end else if (restart_i) begin
            pre_cnt <= '0;
            timer_q <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
            if (timer_q != T_MAX) begin
                timer_q <= timer_q + TMR_W'(1);
            end else if (ratio_i != R_MAX) begin
                timer_q <= T_MID;
            end
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    // R2
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !ovf_o) |=> (timer_q == $past(timer_q)) || (timer_q == $past(timer_q) + TMR_W'(1)));
endmodule

// File: rtl/cdm_capture.sv
// Interval capture pair and prescaler range control.
// On accept the timer value (doubled when the range is refined) becomes the current
// interval and the old current interval the previous one. On overflow both halve
// and the range coarsens. Assumes accept and overflow are exclusive (the timer
// suppresses overflow on restart).
module cdm_capture #(
    parameter int TMR_W     = 8,
    parameter int RATIO_W   = 4,
    parameter int LOW_LIMIT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept_i,
    input  logic               ovf_i,
    input  logic [TMR_W-1:0]   timer_i,
    output logic [TMR_W-1:0]   cap_next_o,
    output logic [TMR_W-1:0]   zcur_o,
    output logic [TMR_W-1:0]   zprev_o,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam logic [RATIO_W-1:0] R_MAX = '1;

    logic [TMR_W-1:0]   zcur_q, zprev_q, zcur_dbl;
    logic [RATIO_W-1:0] ratio_q;
    logic               refine;

    assign refine     = (timer_i < TMR_W'(LOW_LIMIT)) && (ratio_q != '0);
    assign cap_next_o = refine ? {timer_i[TMR_W-2:0], 1'b0} : timer_i;
    assign zcur_dbl   = zcur_q[TMR_W-1] ? '1 : {zcur_q[TMR_W-2:0], 1'b0};
    assign zcur_o     = zcur_q;
    assign zprev_o    = zprev_q;
    assign ratio_o    = ratio_q;

    // Capture shift on accept, unit rescale on refine or overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zcur_q  <= '0;
            zprev_q <= '0;
            ratio_q <= '0;
        end else if (accept_i) begin
            zcur_q  <= cap_next_o;
            zprev_q <= refine ? zcur_dbl : zcur_q;
            if (refine) ratio_q <= ratio_q - RATIO_W'(1);
        end else if (ovf_i && (ratio_q != R_MAX)) begin
            ratio_q <= ratio_q + RATIO_W'(1);
            zcur_q  <= zcur_q >> 1;
            zprev_q <= zprev_q >> 1;
        end
    end

    // R9
    refine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && refine) |=> !zcur_q[0] && (ratio_q == $past(ratio_q) - RATIO_W'(1)));
    // R8
    coarsen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && !accept_i && (ratio_q != R_MAX)) |=>
            (ratio_q == $past(ratio_q) + RATIO_W'(1)) && (zcur_q <= $past(zcur_q)));
endmodule

// File: rtl/cdm_compare.sv
// Delay multiplier and the two timer compares.
// Loads the commutation compare with the high byte of weight x interval when a
// crossing is accepted; reports timer equality with it and timer at-or-above the
// demagnetisation compare. Assumes weight is valid on the loading edge.
module cdm_compare #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] weight_i,
    input  logic [TMR_W-1:0] cap_i,
    input  logic [TMR_W-1:0] timer_i,
    input  logic [TMR_W-1:0] dsim_cmp_i,
    output logic [TMR_W-1:0] cmp_o,
    output logic             hit_c_o,
    output logic             hit_d_o
);
    localparam int PROD_W = 2 * TMR_W;

    logic [PROD_W-1:0] prod;
    logic [TMR_W-1:0]  cmp_q;

    assign prod    = {{TMR_W{1'b0}}, weight_i} * {{TMR_W{1'b0}}, cap_i};
    assign hit_c_o = (timer_i == cmp_q);
    assign hit_d_o = (timer_i >= dsim_cmp_i);
    assign cmp_o   = cmp_q;

    // Commutation compare register load.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (load_i) cmp_q <= prod[PROD_W-1:TMR_W];
    end

    // R3
    delay_below_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cmp_q <= $past(cap_i)));
endmodule

// File: rtl/commutation_delay.sv
// Commutation delay manager top.
// Sequences each step: accept a zero-crossing, wait for the compare match that
// commutes, then wait for demagnetisation end (detected or simulated) before the
// next crossing is accepted. Assumes event inputs are single-cycle pulses.
module commutation_delay #(
    parameter int TMR_W     = 8,
    parameter int RATIO_W   = 4,
    parameter int LOW_LIMIT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               zc_i,
    input  logic               dem_det_i,
    input  logic [TMR_W-1:0]   weight_i,
    input  logic [TMR_W-1:0]   dsim_cmp_i,
    output logic               comm_o,
    output logic               dsim_o,
    output logic               irq_z_o,
    output logic               irq_misc_o,
    output logic [TMR_W-1:0]   zcur_o,
    output logic [TMR_W-1:0]   zprev_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [TMR_W-1:0]   comm_cmp_o
);
    import cdm_pkg::*;

    phase_e             phase_q;
    logic               accept, ovf, hit_c, hit_d;
    logic [TMR_W-1:0]   timer, cap_next;

    assign accept = zc_i && (phase_q == PH_WAIT_Z);

    cdm_tick_timer #(.TMR_W(TMR_W), .RATIO_W(RATIO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .ratio_i(ratio_o), .restart_i(accept),
        .timer_o(timer), .ovf_o(ovf)
    );

    cdm_capture #(.TMR_W(TMR_W), .RATIO_W(RATIO_W), .LOW_LIMIT(LOW_LIMIT)) u_capture (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .ovf_i(ovf), .timer_i(timer),
        .cap_next_o(cap_next), .zcur_o(zcur_o), .zprev_o(zprev_o), .ratio_o(ratio_o)
    );

    cdm_compare #(.TMR_W(TMR_W)) u_compare (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .weight_i(weight_i), .cap_i(cap_next),
        .timer_i(timer), .dsim_cmp_i(dsim_cmp_i), .cmp_o(comm_cmp_o),
        .hit_c_o(hit_c), .hit_d_o(hit_d)
    );

    // Step phase sequencing and event/interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_WAIT_Z;
            comm_o     <= 1'b0;
            dsim_o     <= 1'b0;
            irq_z_o    <= 1'b0;
            irq_misc_o <= 1'b0;
        end else begin
            comm_o     <= 1'b0;
            dsim_o     <= 1'b0;
            irq_z_o    <= accept;
            irq_misc_o <= ovf;
            case (phase_q)
                PH_WAIT_Z: if (accept) phase_q <= PH_WAIT_C;
                PH_WAIT_C: if (hit_c) begin
                    comm_o  <= 1'b1;
                    phase_q <= PH_WAIT_D;
                end
                PH_WAIT_D: if (dem_det_i) begin
                    irq_misc_o <= 1'b1;
                    phase_q    <= PH_WAIT_Z;
                end else if (hit_d) begin
                    dsim_o     <= 1'b1;
                    irq_misc_o <= 1'b1;
                    phase_q    <= PH_WAIT_Z;
                end
                default: phase_q <= PH_WAIT_Z;
            endcase
        end
    end

    // R4
    comm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comm_o |=> !comm_o);
    // R5
    zc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_i && (phase_q != PH_WAIT_Z) && !ovf) |=> $stable(zcur_o) && !irq_z_o);
    // R7
    dsim_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsim_o |-> ($past(timer) >= $past(dsim_cmp_i)));
    // R10
    irq_z_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_z_o |=> !irq_z_o);
endmodule

// File: tb/test_commutation_delay.sv
module test_commutation_delay;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       zc = 1'b0;
    logic       dd = 1'b0;
    logic [7:0] w = 8'd0;
    logic [7:0] dsc = 8'hFF;
    logic       comm_o, dsim_o, irq_z_o, irq_misc_o;
    logic [7:0] zcur_o, zprev_o, comm_cmp_o;
    logic [3:0] ratio_o;

    commutation_delay i_commutation_delay (
        .clk(clk), .rst_n(rst_n), .zc_i(zc), .dem_det_i(dd), .weight_i(w),
        .dsim_cmp_i(dsc), .comm_o(comm_o), .dsim_o(dsim_o), .irq_z_o(irq_z_o),
        .irq_misc_o(irq_misc_o), .zcur_o(zcur_o), .zprev_o(zprev_o),
        .ratio_o(ratio_o), .comm_cmp_o(comm_cmp_o)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int at; int zc; int zp; int r; int cmp; bit chk_zc; bit chk_zp;
    } exp_t;
    exp_t sb[$];

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops expectations at each commutation pulse.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && comm_o) begin
            if (sb.size() == 0) check(1'b0, "R4 unexpected commutation", cyc, -1);
            else begin
                e = sb.pop_front();
                check(cyc == e.at, "R4 commutation cycle", cyc, e.at);
                check(int'(comm_cmp_o) == e.cmp, "R3 compare value", comm_cmp_o, e.cmp);
                check(int'(ratio_o) == e.r, "R2 prescaler code", ratio_o, e.r);
                if (e.chk_zc) check(int'(zcur_o) == e.zc, "R2 current capture", zcur_o, e.zc);
                if (e.chk_zp) check(int'(zprev_o) == e.zp, "R2 previous capture", zprev_o, e.zp);
            end
        end
    end

    int  last_E = 0, m_r = 0, m_zc = 0, m_zp = 0;
    bit  m_known = 1'b0;

    // Driver: issue an accepted crossing d edges after the last one and queue the expectation.
    task automatic z_step(input int d, input int wv, input int dv, input int t_force);
        int E, t, zc_e, zp_e;
        exp_t e;
        E = last_E + d;
        if (cyc >= E - 1) check(1'b0, "R5 bench schedule", cyc, E - 1);
        while (cyc < E - 1) @(negedge clk);
        w = wv[7:0]; dsc = dv[7:0]; zc = 1'b1;
        @(negedge clk);
        zc = 1'b0;
        check(irq_z_o == 1'b1, "R10 irq_z after accepted crossing", irq_z_o, 1);
        t = (t_force >= 0) ? t_force : ((E - last_E - 1) >> m_r);
        if (t < 64 && m_r > 0) begin
            // R9 refine
            zc_e = 2 * t;
            zp_e = (2 * m_zc > 255) ? 255 : 2 * m_zc;
            m_r  = m_r - 1;
        end else begin
            zc_e = t;
            zp_e = m_zc;
        end
        e.zc = zc_e; e.zp = zp_e; e.r = m_r; e.cmp = (wv * zc_e) >> 8;
        e.at = E + e.cmp * (1 << m_r) + 1;
        e.chk_zc = 1'b1; e.chk_zp = m_known;
        sb.push_back(e);
        last_E = E; m_zp = zp_e; m_zc = zc_e; m_known = 1'b1;
    endtask

    task automatic wait_comm();
        do @(negedge clk); while (!comm_o);
    endtask

    task automatic dem_pulse();
        dd = 1'b1;
        @(negedge clk);
        dd = 1'b0;
        check(irq_misc_o == 1'b1, "R6 irq_misc after detected demagnetisation", irq_misc_o, 1);
    endtask

    initial begin
        exp_t e;
        int   O, zc_keep;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(comm_o == 0 && dsim_o == 0 && irq_z_o == 0 && irq_misc_o == 0, "R1 events in reset", comm_o, 0);
        check(zcur_o == 0 && zprev_o == 0 && comm_cmp_o == 0, "R1 registers in reset", zcur_o, 0);
        check(ratio_o == 0, "R1 prescaler code in reset", ratio_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(zcur_o == 0 && ratio_o == 0 && comm_o == 0, "R1 first cycle after reset", zcur_o, 0);

        // Warm-up crossing: weight 0 gives compare 0, capture value not checked.
        w = 8'd0; zc = 1'b1;
        @(negedge clk);
        zc = 1'b0;
        check(irq_z_o == 1'b1, "R10 irq_z first crossing", irq_z_o, 1);
        e.at = cyc + 1; e.zc = 0; e.zp = 0; e.r = 0; e.cmp = 0; e.chk_zc = 0; e.chk_zp = 0;
        sb.push_back(e);
        last_E = cyc; m_known = 1'b0;
        wait_comm(); dem_pulse();

        z_step(101, 128, 255, -1);             // R2 R3 R4: t=100, cmp 50
        wait_comm(); dem_pulse();
        z_step(201, 255, 255, -1);             // R3 max weight: t=200, cmp 199
        wait_comm(); dem_pulse();

        // R5 and R7: crossings during both waits, then simulated demagnetisation at 120.
        z_step(241, 64, 120, -1);              // t=240, cmp 60
        zc_keep = m_zc;
        while (cyc < last_E + 19) @(negedge clk);
        zc = 1'b1; @(negedge clk); zc = 1'b0;
        check(irq_z_o == 1'b0, "R5 crossing ignored before commutation", irq_z_o, 0);
        check(int'(zcur_o) == zc_keep, "R5 capture kept before commutation", zcur_o, zc_keep);
        wait_comm();
        zc = 1'b1; @(negedge clk); zc = 1'b0;
        check(irq_z_o == 1'b0, "R5 crossing ignored during demagnetisation", irq_z_o, 0);
        check(int'(zcur_o) == zc_keep, "R5 capture kept during demagnetisation", zcur_o, zc_keep);
        while (cyc < last_E + 120) @(negedge clk);
        check(dsim_o == 1'b0, "R7 no early simulated end", dsim_o, 0);
        @(negedge clk);
        check(dsim_o == 1'b1, "R7 simulated end at compare", dsim_o, 1);
        check(irq_misc_o == 1'b1, "R7 irq_misc with simulated end", irq_misc_o, 1);
        @(negedge clk);
        check(dsim_o == 1'b0, "R7 simulated end is one cycle", dsim_o, 0);

        // R7 boundary: compare 0 and simulation compare 0.
        z_step(200, 0, 0, -1);
        wait_comm();
        @(negedge clk);
        check(dsim_o == 1'b1, "R7 simulated end right after commutation", dsim_o, 1);

        z_step(101, 128, 255, -1);             // t=100
        wait_comm(); dem_pulse();

        // R8 overflow at code 0.
        O = last_E + 256;
        while (cyc < O - 1) @(negedge clk);
        check(ratio_o == 0, "R8 code before overflow", ratio_o, 0);
        @(negedge clk);
        check(irq_misc_o == 1'b1, "R8 irq_misc on overflow", irq_misc_o, 1);
        check(ratio_o == 1, "R8 code after overflow", ratio_o, 1);
        check(int'(zcur_o) == (m_zc >> 1), "R8 current capture halved", zcur_o, m_zc >> 1);
        check(int'(zprev_o) == (m_zp >> 1), "R8 previous capture halved", zprev_o, m_zp >> 1);
        m_r = 1; m_zc = m_zc >> 1; m_zp = m_zp >> 1;
        z_step(317, 32, 255, 128 + ((317 - 256 - 1) >> 1));   // R8 resume at 128: t=158
        wait_comm(); dem_pulse();

        z_step(61, 100, 255, -1);              // R9 t=30 at code 1 -> 60, code 0
        wait_comm(); dem_pulse();
        z_step(250, 255, 255, -1);             // R3 t=249, cmp 248
        wait_comm(); dem_pulse();

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R4 all commutations seen", sb.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule